// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames (start bit, eight data bits sent least significant bit first, an optional parity bit, one stop bit) on a single input line. It advances only on a base-rate enable that pulses sixteen times per bit period. A start is confirmed by a second look at the line in the middle of the start bit. After that, every later bit is sampled once, in its middle. Bits are shifted into an internal shift register. At the end of the frame, the byte is moved to an output data register or withheld, depending on which errors the frame carries.

Four sticky flags report the outcome of each frame: data-ready, overrun, framing error and parity error. Each flag has its own one-cycle clear strobe. A new frame that arrives while data-ready is still set is an overrun: its byte is discarded and the register keeps the older byte. A frame with only a framing or parity problem still delivers its byte, but does not raise data-ready. Turning the receiver off aborts any frame in progress and leaves all flags and the data register untouched. A line held low keeps producing frames with a bad stop bit, so the framing flag returns after each clear.

Top module: `async_rx`

## Requirements
- R1: The line is sampled on base ticks, sixteen per bit. A low level seen in idle is checked again eight ticks later. If the line is high by then, the event is dropped as a glitch and no frame is received.
- R2: A frame with a high stop bit and no parity error, received while data-ready is 0, copies the byte to rxData and sets data-ready. Data bits arrive least significant bit first.
- R3: If data-ready is already 1 when a frame completes, the frame is an overrun. rxData keeps its old byte, the overrun flag is set and data-ready stays 1.
- R4: A stop bit sampled low without overrun sets the framing flag and copies the byte to rxData, but leaves data-ready at 0.
- R5: With parity enabled, the parity bit follows the eighth data bit. With parityOdd=0, the data bits plus the parity bit must hold an even number of ones; with parityOdd=1, an odd number. A mismatch without overrun sets the parity flag and copies the byte, but leaves data-ready at 0.
- R6: When an overrun coincides with framing and/or parity errors, every error flag involved is set, data-ready reads 1 and rxData is not written.
- R7: While the line stays low (break), frames keep completing with a low stop bit. A framing flag cleared during the break is set again by the next frame.
- R8: Dropping rxEnable aborts any frame in progress. It changes neither rxData nor any of the four flags, and frames sent while it is low are ignored.
- R9: Each clear strobe, held for one cycle, clears its own flag on the next clock edge. If a flag's set condition and its clear strobe occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | Base-rate enable, 16 pulses per bit |
| rxIn | input | 1 | Serial line, idle high |
| rxEnable | input | 1 | Receiver on when 1 |
| parityEn | input | 1 | A parity bit follows the data bits |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| clrFull | input | 1 | Clear strobe for data-ready |
| clrOverrun | input | 1 | Clear strobe for overrun |
| clrFraming | input | 1 | Clear strobe for framing error |
| clrParity | input | 1 | Clear strobe for parity error |
| rxData | output | 8 | Last byte moved to the data register |
| fullFlag | output | 1 | Data-ready flag |
| overrunFlag | output | 1 | Overrun flag |
| framingFlag | output | 1 | Framing error flag |
| parityFlag | output | 1 | Parity error flag |

## Verification
Clean frames with asymmetric bytes such as 0xA5 and 0x81 tell correct bit order and mid-bit sampling apart from reversed or shifted sampling. Frames with a low stop bit, with wrong parity in each sense, and with both together are sent once while data-ready is clear and once while it is set. This separates the withhold-on-overrun decision from the error-only cases that still write the byte. A short low pulse, a frame aborted by disabling the receiver, and a held-low line cover start confirmation, flag retention and the framing flag coming back after a clear. A clear strobe held across a failing frame shows that the flag briefly rises, which tells set-wins apart from clear-wins.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic parCap;
    logic frameDone;
    logic lineBit;
  } rxStrobe_t;
endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      rxIn,
  input  logic      rxEnable,
  input  logic      parityEn,
  output rxStrobe_t strb
);
  localparam int CW   = $clog2(OVS);
  localparam int IW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HALF = OVS / 2;

  logic [1:0]    syncQ;
  logic          lineS;
  rxState_t      state;
  logic [CW-1:0] tickCnt;
  logic [IW-1:0] bitIdx;
  logic          bitEnd;

  assign lineS  = syncQ[1];
  assign bitEnd = (tickCnt == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      syncQ <= {syncQ[0], rxIn};
      if (!rxEnable) begin
        state   <= ST_IDLE;
        tickCnt <= '0;
        bitIdx  <= '0;
      end else if (baudTick) begin
        case (state)
          ST_IDLE: begin
            tickCnt <= '0;
            if (!lineS) state <= ST_START;
          end
          ST_START: begin
            if (tickCnt == CW'(HALF - 1)) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              state   <= lineS ? ST_IDLE : ST_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (bitEnd) begin
              tickCnt <= '0;
              if (bitIdx == IW'(DATA_BITS - 1)) state <= parityEn ? ST_PAR : ST_STOP;
              else bitIdx <= bitIdx + 1'b1;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (bitEnd) begin
              tickCnt <= '0;
              state   <= ST_STOP;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (bitEnd) begin
              tickCnt <= '0;
              state   <= ST_IDLE;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  logic sampleNow;
  assign sampleNow = rxEnable && baudTick && bitEnd;

  always_comb begin
    strb.shiftEn   = sampleNow && (state == ST_DATA);
    strb.parCap    = sampleNow && (state == ST_PAR);
    strb.frameDone = sampleNow && (state == ST_STOP);
    strb.lineBit   = lineS;
  end
endmodule

// File: rtl/rx_dp.sv
module rx_dp
  import rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strb,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 clrFull,
  input  logic                 clrOverrun,
  input  logic                 clrFraming,
  input  logic                 clrParity,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 fullFlag,
  output logic                 overrunFlag,
  output logic                 framingFlag,
  output logic                 parityFlag
);
  logic [DATA_BITS-1:0] shiftQ;
  logic                 parQ;
  logic                 ferr;
  logic                 perr;
  logic                 ovr;

  assign ferr = !strb.lineBit;
  assign perr = parityEn && ((^{shiftQ, parQ}) != parityOdd);
  assign ovr  = fullFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      parQ   <= 1'b0;
    end else begin
      if (strb.shiftEn) shiftQ <= {strb.lineBit, shiftQ[DATA_BITS-1:1]};
      if (strb.parCap)  parQ   <= strb.lineBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData      <= '0;
      fullFlag    <= 1'b0;
      overrunFlag <= 1'b0;
      framingFlag <= 1'b0;
      parityFlag  <= 1'b0;
    end else begin
      if (clrFull)    fullFlag    <= 1'b0;
      if (clrOverrun) overrunFlag <= 1'b0;
      if (clrFraming) framingFlag <= 1'b0;
      if (clrParity)  parityFlag  <= 1'b0;
      if (strb.frameDone) begin
        if (ferr) framingFlag <= 1'b1;
        if (perr) parityFlag  <= 1'b1;
        if (ovr) begin
          overrunFlag <= 1'b1;
          fullFlag    <= 1'b1;
        end else begin
          rxData <= shiftQ;
          if (!ferr && !perr) fullFlag <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/async_rx.sv
module async_rx
  import rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 rxIn,
  input  logic                 rxEnable,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 clrFull,
  input  logic                 clrOverrun,
  input  logic                 clrFraming,
  input  logic                 clrParity,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 fullFlag,
  output logic                 overrunFlag,
  output logic                 framingFlag,
  output logic                 parityFlag
);
  rxStrobe_t strb;

  rx_ctrl #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .baudTick(baudTick),
    .rxIn    (rxIn),
    .rxEnable(rxEnable),
    .parityEn(parityEn),
    .strb    (strb)
  );

  rx_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .parityEn   (parityEn),
    .parityOdd  (parityOdd),
    .clrFull    (clrFull),
    .clrOverrun (clrOverrun),
    .clrFraming (clrFraming),
    .clrParity  (clrParity),
    .rxData     (rxData),
    .fullFlag   (fullFlag),
    .overrunFlag(overrunFlag),
    .framingFlag(framingFlag),
    .parityFlag (parityFlag)
  );
endmodule

// File: rtl/async_rx_checks.sv
module async_rx_checks #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rxEnable,
  input logic                 clrFull,
  input logic                 clrOverrun,
  input logic                 clrFraming,
  input logic                 clrParity,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 fullFlag,
  input logic                 overrunFlag,
  input logic                 framingFlag,
  input logic                 parityFlag
);
  // R3: an overrun never writes the data register
  a_r3_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> rxData == $past(rxData));

  // R3 / R6: data-ready reads 1 whenever an overrun is reported
  a_r6_overrun_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> fullFlag);

  // R4 / R5: an error without overrun leaves data-ready low
  a_r4_error_no_full: assert property (@(posedge clk) disable iff (!rstN)
    (($rose(framingFlag) || $rose(parityFlag)) && !$past(fullFlag)) |-> !fullFlag);

  // R8: while disabled, only clear strobes may move the flags
  a_r8_keep_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !clrOverrun) |=> $stable(overrunFlag));
  a_r8_keep_framing: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !clrFraming) |=> $stable(framingFlag));
  a_r8_keep_parity: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !clrParity) |=> $stable(parityFlag));
  a_r8_keep_full: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !clrFull) |=> $stable(fullFlag));
  a_r8_keep_data: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> $stable(rxData));
endmodule

bind async_rx async_rx_checks #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxEnable   (rxEnable),
  .clrFull    (clrFull),
  .clrOverrun (clrOverrun),
  .clrFraming (clrFraming),
  .clrParity  (clrParity),
  .rxData     (rxData),
  .fullFlag   (fullFlag),
  .overrunFlag(overrunFlag),
  .framingFlag(framingFlag),
  .parityFlag (parityFlag)
);

// File: tb/async_rx_tb.sv
module async_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b1;
  logic       rxIn = 1'b1;
  logic       rxEnable = 1'b1;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       clrFull = 1'b0, clrOverrun = 1'b0, clrFraming = 1'b0, clrParity = 1'b0;
  logic [7:0] rxData;
  logic       fullFlag, overrunFlag, framingFlag, parityFlag;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  logic [11:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  async_rx u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxIn(rxIn),
    .rxEnable(rxEnable), .parityEn(parityEn), .parityOdd(parityOdd),
    .clrFull(clrFull), .clrOverrun(clrOverrun), .clrFraming(clrFraming),
    .clrParity(clrParity), .rxData(rxData), .fullFlag(fullFlag),
    .overrunFlag(overrunFlag), .framingFlag(framingFlag), .parityFlag(parityFlag)
  );

  // monitor: pops expected states and compares against the outputs
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [11:0] e;
      logic [11:0] a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = {rxData, fullFlag, overrunFlag, framingFlag, parityFlag};
      testCount++;
      if (a !== e) begin
        failCount++;
        $display("FAIL %s: data/full/ovr/fer/per actual %h/%b%b%b%b expected %h/%b%b%b%b",
                 t, a[11:4], a[3], a[2], a[1], a[0], e[11:4], e[3], e[2], e[1], e[0]);
      end
    end
  end

  task automatic waitClks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chkState(input string tag, input logic [7:0] d,
                          input logic f, input logic o, input logic fe, input logic pe);
    expQ.push_back({d, f, o, fe, pe});
    tagQ.push_back(tag);
    waitClks(2);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit usePar,
                           input bit parBit, input bit stopBit);
    @(negedge clk);
    rxIn = 1'b0;
    waitClks(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      rxIn = d[i];
      waitClks(BIT_CLKS);
    end
    if (usePar) begin
      rxIn = parBit;
      waitClks(BIT_CLKS);
    end
    rxIn = stopBit;
    waitClks(BIT_CLKS);
    rxIn = 1'b1;
    waitClks(BIT_CLKS);
  endtask

  task automatic clearAll();
    @(negedge clk);
    clrFull = 1'b1; clrOverrun = 1'b1; clrFraming = 1'b1; clrParity = 1'b1;
    @(negedge clk);
    clrFull = 1'b0; clrOverrun = 1'b0; clrFraming = 1'b0; clrParity = 1'b0;
  endtask

  bit watchFer = 1'b0;
  bit seenFer = 1'b0;
  always @(negedge clk) if (watchFer && framingFlag) seenFer = 1'b1;

  initial begin
    waitClks(3);
    rstN = 1'b1;
    waitClks(2);
    chkState("R2 reset state", 8'h00, 0, 0, 0, 0);

    sendFrame(8'hA5, 0, 0, 1);
    chkState("R2 clean frame", 8'hA5, 1, 0, 0, 0);

    sendFrame(8'h3C, 0, 0, 1);
    chkState("R3 overrun withholds byte", 8'hA5, 1, 1, 0, 0);

    clearAll();
    chkState("R9 clear strobes", 8'hA5, 0, 0, 0, 0);

    sendFrame(8'h5A, 0, 0, 0);
    chkState("R4 framing only", 8'h5A, 0, 0, 1, 0);
    clearAll();

    parityEn = 1'b1; parityOdd = 1'b0;
    sendFrame(8'h07, 1, ^8'h07, 1);
    chkState("R5 even parity good", 8'h07, 1, 0, 0, 0);
    clearAll();

    sendFrame(8'h81, 1, ~(^8'h81), 1);
    chkState("R5 even parity bad", 8'h81, 0, 0, 0, 1);
    clearAll();

    parityOdd = 1'b1;
    sendFrame(8'h33, 1, ~(^8'h33), 1);
    chkState("R5 odd parity good", 8'h33, 1, 0, 0, 0);

    sendFrame(8'h99, 1, ^8'h99, 0);
    chkState("R6 overrun+framing+parity", 8'h33, 1, 1, 1, 1);

    clearAll();
    @(negedge clk);
    rxIn = 1'b0;
    waitClks(4);
    rxIn = 1'b1;
    waitClks(300);
    chkState("R1 glitch ignored", 8'h33, 0, 0, 0, 0);

    sendFrame(8'h44, 1, ^8'h44, 0);
    chkState("R8 setup flags", 8'h44, 0, 0, 1, 1);
    fork
      sendFrame(8'hFF, 1, ~(^8'hFF), 1);
    join_none
    waitClks(60);
    rxEnable = 1'b0;
    waitClks(250);
    chkState("R8 abort keeps flags", 8'h44, 0, 0, 1, 1);
    sendFrame(8'h12, 1, ~(^8'h12), 1);
    chkState("R8 disabled ignores frame", 8'h44, 0, 0, 1, 1);
    rxEnable = 1'b1;
    waitClks(4);

    parityEn = 1'b0;
    clearAll();
    chkState("R9 clear after disable", 8'h44, 0, 0, 0, 0);

    @(negedge clk);
    clrFraming = 1'b1;
    watchFer = 1'b1;
    sendFrame(8'h10, 0, 0, 0);
    @(negedge clk);
    clrFraming = 1'b0;
    watchFer = 1'b0;
    testCount++;
    if (!seenFer) begin
      failCount++;
      $display("FAIL R9 set wins over clear: flag seen %0b expected 1", seenFer);
    end
    chkState("R9 held clear drops flag", 8'h10, 0, 0, 0, 0);

    @(negedge clk);
    rxIn = 1'b0;
    waitClks(200);
    chkState("R7 break sets framing", 8'h00, 0, 0, 1, 0);
    @(negedge clk);
    clrFraming = 1'b1;
    @(negedge clk);
    clrFraming = 1'b0;
    chkState("R9 framing cleared in break", 8'h00, 0, 0, 0, 0);
    waitClks(200);
    chkState("R7 break sets framing again", 8'h00, 0, 0, 1, 0);
    rxIn = 1'b1;
    waitClks(400);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    waitClks(150000);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule